// File: doc/BRIEF.md
# Event Queue Ring Writer

This block appends one 32-bit entry to a ring buffer held in memory. The caller supplies the event payload together with the queue descriptor fields: the two parts of the base address, a size code, the current write index and the current generation bit. The block forms the entry address and the entry word. It issues one write on a simple request/response memory port. When the write completes, it returns the index and generation bit that the descriptor store should write back.

Every entry carries the generation bit in its most significant position. That bit flips each time the write index wraps to zero. A consumer can therefore tell fresh entries from stale ones without a shared tail pointer. The block handles one push at a time. A size code beyond the configured maximum is refused without touching memory.

The control is a four-state machine:
- `S_IDLE`: waiting for a push.
- `S_ISSUE`: the memory request is presented.
- `S_WAIT`: the request was granted and the block waits for the response.
- `S_DONE`: the one-cycle result pulse.

The transitions are:
- *accept*: `S_IDLE` to `S_ISSUE`, on a push with a valid size code.
- *reject*: `S_IDLE` to `S_DONE`, on a push with an oversized code.
- *granted*: `S_ISSUE` to `S_WAIT`, when `mem_req_ready` is high.
- *answered*: `S_WAIT` to `S_DONE`, when `mem_rsp_valid` is high.
- *release*: `S_DONE` to `S_IDLE`, unconditionally.

Top module: `eqw_ring_writer`

## Requirements
- R1: After reset `push_ready` is high, and `mem_req_valid` and `done_valid` are low.
- R2: The write address is `{push_base_hi, push_base_lo}` plus four times the effective index, taken modulo 2^60.
- R3: The entry word has the generation bit in bit 31 and `push_data` in bits 30:0. It is stored big-endian. Byte lane k of `mem_req_data` (bits 8k+7:8k) targets address+k, so bits 7:0 carry word bits 31:24 and bits 31:24 carry word bits 7:0.
- R4: The ring holds 2^(size code + 10) entries. The effective index is `push_index` modulo that count, so index bits above the ring size are ignored.
- R5: After a successful write, `done_index` is (effective index + 1) modulo the entry count. `done_gen` is the inverted input generation bit exactly when `done_index` is zero; otherwise it equals the input bit.
- R6: When the memory response flags an error, `done_err` is high, `done_index` equals the `push_index` given, and `done_gen` equals the `push_gen` given.
- R7: `push_ready` is low from the cycle after acceptance until the cycle after the `done_valid` pulse.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and data stay unchanged.
- R9: `mem_rsp_valid` is ignored until the request has been granted.
- R10: `done_valid` is a single-cycle pulse, one cycle after the answering response or after a rejected push.
- R11: A size code above 6 issues no memory request. In the cycle after acceptance it gives `done_valid` with `done_err` high and the given index and generation bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Block can accept a push |
| push_data | input | 31 | Event payload |
| push_base_hi | input | 28 | Upper base address bits (low 28 bits of the descriptor word) |
| push_base_lo | input | 32 | Lower base address bits |
| push_size | input | 4 | Ring size code |
| push_index | input | 16 | Current write index |
| push_gen | input | 1 | Current generation bit |
| mem_req_valid | output | 1 | Memory write request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 60 | Byte address of the entry |
| mem_req_data | output | 32 | Entry in memory byte order |
| mem_rsp_valid | input | 1 | Write response |
| mem_rsp_err | input | 1 | Write failed |
| done_valid | output | 1 | Result pulse |
| done_err | output | 1 | Write failed or size refused |
| done_index | output | 16 | Index to write back |
| done_gen | output | 1 | Generation bit to write back |

## Verification
The assertions assume that the memory side answers each granted request with exactly one `mem_rsp_valid` pulse. They also assume that the push inputs are held stable while `push_valid` is high and not yet accepted. The bench acts as the memory with these rules and adds random grant and response delays. It sometimes injects stray responses before the grant, which the block must ignore. Size codes, indices near the wrap point, and error responses are drawn at random. Directed cases cover the wrap in both generation states, the largest legal size, the first refused size, and an error on the last slot.

// File: rtl/eqw_pkg.sv
package eqw_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } eqw_state_e;
endpackage

// File: rtl/eqw_entry_former.sv
module eqw_entry_former #(
    parameter int DATA_W    = 31,
    parameter int BASE_HI_W = 28,
    parameter int BASE_LO_W = 32,
    parameter int SZ_W      = 4,
    parameter int MIN_LOG   = 10,
    parameter int MAX_SZ    = 6,
    parameter bit BIG_END   = 1'b1,
    localparam int IDX_W    = MIN_LOG + MAX_SZ,
    localparam int ADDR_W   = BASE_HI_W + BASE_LO_W,
    localparam int WORD_W   = DATA_W + 1,
    localparam int LANES    = WORD_W / 8
) (
    input  logic [DATA_W-1:0]    data,
    input  logic [BASE_HI_W-1:0] base_hi,
    input  logic [BASE_LO_W-1:0] base_lo,
    input  logic [SZ_W-1:0]      size_code,
    input  logic [IDX_W-1:0]     index,
    input  logic                 gen,
    output logic                 size_ok,
    output logic [IDX_W-1:0]     mask,
    output logic [IDX_W-1:0]     idx_eff,
    output logic [ADDR_W-1:0]    addr,
    output logic [WORD_W-1:0]    bus_word
);
    logic [IDX_W:0]    span;
    logic [WORD_W-1:0] entry;
    int                shamt;

    always_comb begin
        size_ok = (size_code <= SZ_W'(MAX_SZ));
        shamt   = int'(size_code) + MIN_LOG;
        span    = {{IDX_W{1'b0}}, 1'b1} << shamt;
        mask    = span[IDX_W-1:0] - IDX_W'(1);
        idx_eff = index & mask;
        addr    = {base_hi, base_lo} + ADDR_W'({idx_eff, 2'b00});
        entry   = {gen, data};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (BIG_END) begin : g_swap
            assign bus_word[8*k +: 8] = entry[8*(LANES-1-k) +: 8];
        end else begin : g_flat
            assign bus_word[8*k +: 8] = entry[8*k +: 8];
        end
    end
endmodule

// File: rtl/eqw_ring_step.sv
module eqw_ring_step #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] idx_eff,
    input  logic [IDX_W-1:0] mask,
    input  logic             gen,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             nxt_gen
);
    logic [IDX_W-1:0] bumped;
    logic             wrapped;

    always_comb begin
        bumped  = idx_eff + IDX_W'(1);
        nxt_idx = bumped & mask;
        wrapped = (nxt_idx == '0);
        nxt_gen = gen ^ wrapped;
    end
endmodule

// File: rtl/eqw_ctrl.sv
module eqw_ctrl
    import eqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic       size_ok,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    output eqw_state_e state,
    output logic       push_ready,
    output logic       mem_req_valid,
    output logic       done_valid,
    output logic       accept,
    output logic       answered
);
    eqw_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (push_valid)    state_nxt = size_ok ? S_ISSUE : S_DONE;
            S_ISSUE: if (mem_req_ready) state_nxt = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) state_nxt = S_DONE;
            S_DONE:                     state_nxt = S_IDLE;
            default:                    state_nxt = S_IDLE;
        endcase
    end

    always_comb begin
        push_ready    = 1'b0;
        mem_req_valid = 1'b0;
        done_valid    = 1'b0;
        accept        = 1'b0;
        answered      = 1'b0;
        unique case (state)
            S_IDLE: begin
                push_ready = 1'b1;
                accept     = push_valid;
            end
            S_ISSUE: mem_req_valid = 1'b1;
            S_WAIT:  answered      = mem_rsp_valid;
            S_DONE:  done_valid    = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/eqw_ring_writer.sv
module eqw_ring_writer #(
    parameter int DATA_W    = 31,
    parameter int BASE_HI_W = 28,
    parameter int BASE_LO_W = 32,
    parameter int SZ_W      = 4,
    parameter int MIN_LOG   = 10,
    parameter int MAX_SZ    = 6,
    parameter bit BIG_END   = 1'b1,
    localparam int IDX_W    = MIN_LOG + MAX_SZ,
    localparam int ADDR_W   = BASE_HI_W + BASE_LO_W,
    localparam int WORD_W   = DATA_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_valid,
    output logic                 push_ready,
    input  logic [DATA_W-1:0]    push_data,
    input  logic [BASE_HI_W-1:0] push_base_hi,
    input  logic [BASE_LO_W-1:0] push_base_lo,
    input  logic [SZ_W-1:0]      push_size,
    input  logic [IDX_W-1:0]     push_index,
    input  logic                 push_gen,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic [WORD_W-1:0]    mem_req_data,
    input  logic                 mem_rsp_valid,
    input  logic                 mem_rsp_err,
    output logic                 done_valid,
    output logic                 done_err,
    output logic [IDX_W-1:0]     done_index,
    output logic                 done_gen
);
    import eqw_pkg::*;

    eqw_state_e        state;
    logic              accept, answered, size_ok;
    logic [IDX_W-1:0]  mask, idx_eff, nxt_idx;
    logic              nxt_gen;
    logic [ADDR_W-1:0] f_addr;
    logic [WORD_W-1:0] f_word;

    logic [ADDR_W-1:0] q_addr;
    logic [WORD_W-1:0] q_word;
    logic [IDX_W-1:0]  q_raw_idx, q_nxt_idx;
    logic              q_raw_gen, q_nxt_gen, q_err;

    eqw_entry_former #(
        .DATA_W(DATA_W), .BASE_HI_W(BASE_HI_W), .BASE_LO_W(BASE_LO_W),
        .SZ_W(SZ_W), .MIN_LOG(MIN_LOG), .MAX_SZ(MAX_SZ), .BIG_END(BIG_END)
    ) u_former (
        .data(push_data), .base_hi(push_base_hi), .base_lo(push_base_lo),
        .size_code(push_size), .index(push_index), .gen(push_gen),
        .size_ok(size_ok), .mask(mask), .idx_eff(idx_eff),
        .addr(f_addr), .bus_word(f_word)
    );

    eqw_ring_step #(.IDX_W(IDX_W)) u_step (
        .idx_eff(idx_eff), .mask(mask), .gen(push_gen),
        .nxt_idx(nxt_idx), .nxt_gen(nxt_gen)
    );

    eqw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .size_ok(size_ok),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .state(state), .push_ready(push_ready), .mem_req_valid(mem_req_valid),
        .done_valid(done_valid), .accept(accept), .answered(answered)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr    <= '0;
            q_word    <= '0;
            q_raw_idx <= '0;
            q_nxt_idx <= '0;
            q_raw_gen <= 1'b0;
            q_nxt_gen <= 1'b0;
            q_err     <= 1'b0;
        end else if (accept) begin
            q_addr    <= f_addr;
            q_word    <= f_word;
            q_raw_idx <= push_index;
            q_raw_gen <= push_gen;
            q_nxt_idx <= nxt_idx;
            q_nxt_gen <= nxt_gen;
            q_err     <= !size_ok;
        end else if (answered) begin
            q_err     <= mem_rsp_err;
        end
    end

    always_comb begin
        mem_req_addr = q_addr;
        mem_req_data = q_word;
        done_err     = q_err;
        done_index   = q_err ? q_raw_idx : q_nxt_idx;
        done_gen     = q_err ? q_raw_gen : q_nxt_gen;
    end
endmodule

// File: rtl/eqw_ring_writer_chk.sv
module eqw_ring_writer_chk #(
    parameter int SZ_W   = 4,
    parameter int MAX_SZ = 6,
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 60,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              push_ready,
    input logic [SZ_W-1:0]   push_size,
    input logic [IDX_W-1:0]  push_index,
    input logic              push_gen,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [WORD_W-1:0] mem_req_data,
    input logic              done_valid,
    input logic              done_err,
    input logic [IDX_W-1:0]  done_index,
    input logic              done_gen
);
    logic             took;
    logic [IDX_W-1:0] cap_idx;
    logic             cap_gen;

    assign took = push_valid && push_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_idx <= '0;
            cap_gen <= 1'b0;
        end else if (took) begin
            cap_idx <= push_index;
            cap_gen <= push_gen;
        end
    end

    p_ready_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done_valid) |-> !push_ready);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    p_err_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_err) |-> (done_index == cap_idx && done_gen == cap_gen));

    p_gen_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_err) |-> ((done_gen != cap_gen) == (done_index == '0)));

    p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (took && push_size > SZ_W'(MAX_SZ)) |=> (done_valid && done_err && !mem_req_valid));
endmodule

bind eqw_ring_writer eqw_ring_writer_chk #(
    .SZ_W(SZ_W), .MAX_SZ(MAX_SZ), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/tb_eqw_ring_writer.sv
module tb_eqw_ring_writer;
    localparam int IDX_W  = 16;
    localparam int MAX_SZ = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [30:0] push_data = '0;
    logic [27:0] push_base_hi = '0;
    logic [31:0] push_base_lo = '0;
    logic [3:0]  push_size = '0;
    logic [15:0] push_index = '0;
    logic        push_gen = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [59:0] mem_req_addr;
    logic [31:0] mem_req_data;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic        done_valid, done_err, done_gen;
    logic [15:0] done_index;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    eqw_ring_writer dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_mask(input logic [3:0] sz);
        return 16'((32'd1 << (sz + 10)) - 1);
    endfunction

    function automatic logic [59:0] exp_addr(input logic [27:0] hi, input logic [31:0] lo,
                                             input logic [3:0] sz, input logic [15:0] idx);
        return {hi, lo} + 60'(idx & exp_mask(sz)) * 60'd4;
    endfunction

    function automatic logic [31:0] exp_bus(input logic g, input logic [30:0] d);
        logic [31:0] w;
        w = {g, d};
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic do_push(input logic [30:0] d, input logic [27:0] hi, input logic [31:0] lo,
                           input logic [3:0] sz, input logic [15:0] idx, input logic g,
                           input bit err, input int rdly, input int wdly, input bit stray);
        logic [15:0] nidx;
        logic        ngen;
        logic [59:0] ea;
        logic [31:0] ed;
        @(negedge clk);
        push_data = d; push_base_hi = hi; push_base_lo = lo;
        push_size = sz; push_index = idx; push_gen = g; push_valid = 1'b1;
        chk(push_ready == 1'b1, "R7 idle ready", 64'(push_ready), 64'd1);
        @(negedge clk);
        push_valid = 1'b0;
        push_data = 31'($urandom); push_index = 16'($urandom); push_gen = ~g;
        if (sz > 4'(MAX_SZ)) begin
            chk(done_valid && done_err, "R11 reject pulse", {62'd0, done_valid, done_err}, 64'd3);
            chk(!mem_req_valid, "R11 no request", 64'(mem_req_valid), 64'd0);
            chk(done_index == idx && done_gen == g, "R11 index kept",
                {47'd0, done_gen, done_index}, {47'd0, g, idx});
            @(negedge clk);
            chk(!done_valid && push_ready, "R10 reject pulse ends",
                {62'd0, done_valid, push_ready}, 64'd1);
            return;
        end
        ea = exp_addr(hi, lo, sz, idx);
        ed = exp_bus(g, d);
        chk(mem_req_valid && !push_ready, "R7 busy after accept",
            {62'd0, mem_req_valid, push_ready}, 64'd2);
        chk(mem_req_addr == ea, "R2 R4 address", 64'(mem_req_addr), 64'(ea));
        chk(mem_req_data == ed, "R3 entry bytes", 64'(mem_req_data), 64'(ed));
        for (int i = 0; i < rdly; i++) begin
            mem_req_ready = 1'b0;
            if (stray) begin mem_rsp_valid = 1'b1; mem_rsp_err = 1'b1; end
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
            chk(mem_req_valid && mem_req_addr == ea && mem_req_data == ed, "R8 request held",
                {mem_req_valid, 3'd0, mem_req_addr}, {1'b1, 3'd0, ea});
            chk(!done_valid, "R9 early response ignored", 64'(done_valid), 64'd0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < wdly; i++) begin
            chk(!mem_req_valid && !push_ready && !done_valid, "R7 waiting",
                {61'd0, mem_req_valid, push_ready, done_valid}, 64'd0);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_err = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
        nidx = ((idx & exp_mask(sz)) + 16'd1) & exp_mask(sz);
        ngen = (nidx == 16'd0) ? ~g : g;
        chk(done_valid && done_err == err, "R10 R6 done pulse",
            {62'd0, done_valid, done_err}, {62'd0, 1'b1, err});
        if (err)
            chk(done_index == idx && done_gen == g, "R6 index unchanged",
                {47'd0, done_gen, done_index}, {47'd0, g, idx});
        else
            chk(done_index == nidx && done_gen == ngen, "R5 R4 advance",
                {47'd0, done_gen, done_index}, {47'd0, ngen, nidx});
        @(negedge clk);
        chk(!done_valid && push_ready, "R10 R7 pulse ends",
            {62'd0, done_valid, push_ready}, 64'd1);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(push_ready && !mem_req_valid && !done_valid, "R1 reset state",
            {61'd0, push_ready, mem_req_valid, done_valid}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(push_ready && !mem_req_valid && !done_valid, "R1 after release",
            {61'd0, push_ready, mem_req_valid, done_valid}, 64'd4);
        // directed corners
        do_push(31'h1234_5678, 28'hABCDEF1, 32'hFFFF_FFF0, 4'd0, 16'h03FF, 1'b0, 1'b0, 0, 0, 1'b0); // R5 wrap 0->1
        do_push(31'h7FFF_FFFF, 28'h0000001, 32'h0000_0000, 4'd0, 16'h03FF, 1'b1, 1'b0, 2, 1, 1'b1); // R5 wrap 1->0
        do_push(31'h0000_0001, 28'h0, 32'h1000, 4'd6, 16'hFFFF, 1'b0, 1'b0, 1, 0, 1'b0);  // R4 largest size
        do_push(31'h0000_0002, 28'h0, 32'h1000, 4'd7, 16'h0010, 1'b1, 1'b0, 0, 0, 1'b0);  // R11 first refused
        do_push(31'h0000_0003, 28'h0, 32'h2000, 4'd15, 16'h0020, 1'b0, 1'b0, 0, 0, 1'b0); // R11 largest code
        do_push(31'h0ABC_DEF0, 28'hFFFFFFF, 32'hFFFF_FFFC, 4'd1, 16'h07FF, 1'b1, 1'b1, 1, 2, 1'b1); // R6 error at wrap
        do_push(31'h5555_AAAA, 28'h123, 32'h0, 4'd2, 16'hF005, 1'b0, 1'b0, 0, 0, 1'b0);   // R4 high bits dropped
        for (int n = 0; n < 300; n++) begin
            logic [3:0]  sz;
            logic [15:0] ix;
            sz = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(7, 15)) : 4'($urandom_range(0, 6));
            ix = 16'($urandom);
            if ($urandom_range(0, 3) == 0) ix = ix | exp_mask(sz);
            do_push(31'($urandom), 28'($urandom), $urandom, sz, ix, 1'($urandom),
                    ($urandom_range(0, 4) == 0), $urandom_range(0, 3), $urandom_range(0, 3),
                    1'($urandom));
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule